// File: doc/BRIEF.md
# Receive Buffer Word Writer

This block takes a received frame as a byte stream and stores it in memory buffers that a descriptor supplies, one buffer at a time. Each descriptor gives a buffer start address, which need not be word aligned, and a buffer size in bytes. The block writes only whole 64-bit words, beginning at the start address rounded down to the word boundary. Byte lanes that hold no frame data are disabled on the write port and carry zero as filler.

A buffer is closed when its usable space is used up or when the frame ends, whichever happens first. When a buffer closes, the block emits a one-cycle status word with first-segment and last-segment flags. On the last segment, the status word also carries the total frame length. The programmed buffer size is never written back or changed. A new frame always starts in the buffer of a fresh descriptor. Stalls on the write port hold back the byte stream, and no bytes are lost.

Top module: `rxbuf_word_writer`

## Requirements
- R1: After reset, `desc_ready` is 1, and `in_ready`, `wr_valid` and `st_valid` are 0.
- R2: Every write address has its three low bits at zero. The first write of a buffer goes to the start address rounded down. Each later write of the same buffer goes 8 bytes higher.
- R3: In `wr_be`, bit k enables byte lane k, which is `wr_data[8k+7:8k]`. Lanes below the start offset in the first word are disabled. Lanes after the final byte of a buffer are disabled. Disabled lanes leave memory unchanged.
- R4: For a start offset of 2 and a 16-byte frame, exactly 3 words are written, with byte enables 0xFC, 0xFF and 0x03.
- R5: The usable space of a buffer is its size minus the start offset (address bits 2:0). When that space fills, the buffer closes and the next byte goes to the next descriptor.
- R6: When a frame ends, its buffer closes even if space remains. The following frame starts at the next descriptor's address.
- R7: A status word is emitted once per closed buffer. Bit 1 (first) is set only for the first buffer of a frame. Bit 0 (last) is set only for the buffer that holds the final byte, including when the frame ends exactly at the buffer's end.
- R8: Status bits 29:16 hold the total frame length in bytes when bit 0 is set, and zero otherwise. All other status bits are zero.
- R9: While `wr_valid` is 1 and `wr_ready` is 0, the write request (valid, address, data, enables) stays unchanged and no input byte is accepted.
- R10: Frame byte n is written to the address of the buffer's start plus its position, in stream order, across all buffers of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| desc_valid | input | 1 | A buffer descriptor is offered |
| desc_ready | output | 1 | Block takes a descriptor |
| desc_addr | input | 32 | Buffer start byte address |
| desc_size | input | 14 | Buffer size in bytes (must exceed the start offset) |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts an input byte |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the final byte of a frame |
| wr_valid | output | 1 | Word write request |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | 32 | Word-aligned write address |
| wr_data | output | 64 | Write data, lane k at bits 8k+7:8k |
| wr_be | output | 8 | Byte-lane enables |
| st_valid | output | 1 | Status word valid for one cycle |
| st_word | output | 32 | Status: bit 0 last, bit 1 first, bits 29:16 frame length |

## Verification
On every cycle, the assertions check the following: write addresses are word aligned, a pending write is held steady under backpressure, a byte lane is never filled twice in one word, and no byte is taken once the buffer is full. They also check that a non-last status only follows a full buffer, and that a last status has a nonzero length. Some behaviour shows only in the bench's scenarios: where bytes actually land in memory, that dummy lanes are left untouched, the word count for each offset, frames that end exactly on a buffer boundary, and a new frame moving to a fresh descriptor.

// File: rtl/rxw_pkg.sv
// Package: shared state encoding and status word layout for the receive
// buffer word writer. Assumes a 32-bit status word.
package rxw_pkg;
    typedef enum logic [1:0] {
        ST_DESC  = 2'd0,
        ST_FILL  = 2'd1,
        ST_WRITE = 2'd2,
        ST_STAT  = 2'd3
    } wr_state_t;

    localparam int STATUS_W    = 32;
    localparam int BIT_LAST    = 0;
    localparam int BIT_FIRST   = 1;
    localparam int LEN_LSB     = 16;
endpackage

// File: rtl/rxw_lane_packer.sv
// Lane packer: collects bytes into one bus word at the lane the controller
// selects, and records which lanes hold real data. Assumes the controller
// clears the word before each new word and never selects a lane twice.
module rxw_lane_packer #(
    parameter int BYTES  = 8,
    localparam int LANE_W = $clog2(BYTES),
    localparam int DATA_W = BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              put,
    input  logic [LANE_W-1:0] lane,
    input  logic [7:0]        din,
    output logic [DATA_W-1:0] data,
    output logic [BYTES-1:0]  be
);
    // Per-lane storage; filler lanes stay zero.
    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                data[g*8 +: 8] <= '0;
                be[g]          <= 1'b0;
            end else if (put && lane == LANE_W'(g)) begin
                data[g*8 +: 8] <= din;
                be[g]          <= 1'b1;
            end
        end
    end

    // R10: a lane never receives two bytes within one word
    a_r10_lane_once: assert property (@(posedge clk) disable iff (!rst_n)
        (put && !clear) |-> !be[lane]);
endmodule

// File: rtl/rxw_seg_ctrl.sv
// Segment controller: takes descriptors, tracks lane, usable space and frame
// length, sequences word writes and emits one status per closed buffer.
// Assumes desc_size is larger than the start offset of desc_addr.
module rxw_seg_ctrl
    import rxw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 14,
    parameter int LEN_W  = 14,
    parameter int BYTES  = 8,
    localparam int LANE_W = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_valid,
    output logic              desc_ready,
    input  logic [ADDR_W-1:0] desc_addr,
    input  logic [SIZE_W-1:0] desc_size,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              word_clear,
    output logic              byte_put,
    output logic [LANE_W-1:0] lane,
    output logic              st_valid,
    output logic              st_first,
    output logic              st_last,
    output logic [LEN_W-1:0]  st_len
);
    wr_state_t         state_q;
    logic [ADDR_W-1:0] word_addr_q;
    logic [LANE_W-1:0] lane_q;
    logic [SIZE_W-1:0] space_q;
    logic [LEN_W-1:0]  len_q;
    logic              first_q;
    logic              last_q;
    logic              desc_take;
    logic              wr_take;
    logic              close_buf;

    // Handshake decode from the current state.
    always_comb begin
        desc_ready = (state_q == ST_DESC);
        in_ready   = (state_q == ST_FILL);
        wr_valid   = (state_q == ST_WRITE);
        st_valid   = (state_q == ST_STAT);
        desc_take  = desc_ready && desc_valid;
        byte_put   = in_ready && in_valid;
        wr_take    = wr_valid && wr_ready;
        close_buf  = last_q || (space_q == '0);
        word_clear = desc_take || (wr_take && !close_buf);
    end

    assign wr_addr  = word_addr_q;
    assign lane     = lane_q;
    assign st_first = first_q;
    assign st_last  = last_q;
    assign st_len   = last_q ? len_q : '0;

    // Main sequencer: descriptor intake, byte fill, word write, status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_DESC;
            word_addr_q <= '0;
            lane_q      <= '0;
            space_q     <= '0;
            len_q       <= '0;
            first_q     <= 1'b1;
            last_q      <= 1'b0;
        end else begin
            unique case (state_q)
                ST_DESC: if (desc_take) begin
                    word_addr_q <= {desc_addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
                    lane_q      <= desc_addr[LANE_W-1:0];
                    space_q     <= desc_size - SIZE_W'(desc_addr[LANE_W-1:0]);
                    state_q     <= ST_FILL;
                end
                ST_FILL: if (byte_put) begin
                    space_q <= space_q - 1'b1;
                    len_q   <= len_q + 1'b1;
                    if (in_last) last_q <= 1'b1;
                    if (lane_q == LANE_W'(BYTES - 1) || space_q == SIZE_W'(1) || in_last)
                        state_q <= ST_WRITE;
                    else
                        lane_q <= lane_q + 1'b1;
                end
                ST_WRITE: if (wr_take) begin
                    if (close_buf) begin
                        state_q <= ST_STAT;
                    end else begin
                        word_addr_q <= word_addr_q + ADDR_W'(BYTES);
                        lane_q      <= '0;
                        state_q     <= ST_FILL;
                    end
                end
                ST_STAT: begin
                    state_q <= ST_DESC;
                    if (last_q) begin
                        first_q <= 1'b1;
                        last_q  <= 1'b0;
                        len_q   <= '0;
                    end else begin
                        first_q <= 1'b0;
                    end
                end
                default: state_q <= ST_DESC;
            endcase
        end
    end

    // R2: write addresses are word aligned
    a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_addr[LANE_W-1:0] == '0));
    // R9: a stalled write keeps its address and stays pending
    a_r9_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr)));
    // R5: no byte is taken once the usable space is exhausted
    a_r5_space: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (space_q != '0));
    // R7: a non-last status only follows a full buffer
    a_r7_full_close: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_last) |-> (space_q == '0));
    // R8: a last status carries a nonzero length
    a_r8_len: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_last) |-> (st_len != '0));
endmodule

// File: rtl/rxbuf_word_writer.sv
// Receive buffer word writer top: joins the segment controller and lane
// packer, and formats the status word. Assumes one frame at a time on the
// byte stream and a descriptor size larger than its start offset.
module rxbuf_word_writer
    import rxw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 14,
    parameter int LEN_W  = 14,
    parameter int BYTES  = 8,
    localparam int LANE_W = $clog2(BYTES),
    localparam int DATA_W = BYTES * 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                desc_valid,
    output logic                desc_ready,
    input  logic [ADDR_W-1:0]   desc_addr,
    input  logic [SIZE_W-1:0]   desc_size,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [7:0]          in_data,
    input  logic                in_last,
    output logic                wr_valid,
    input  logic                wr_ready,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [DATA_W-1:0]   wr_data,
    output logic [BYTES-1:0]    wr_be,
    output logic                st_valid,
    output logic [STATUS_W-1:0] st_word
);
    logic              word_clear;
    logic              byte_put;
    logic [LANE_W-1:0] lane;
    logic              st_first;
    logic              st_last;
    logic [LEN_W-1:0]  st_len;

    rxw_seg_ctrl #(
        .ADDR_W (ADDR_W),
        .SIZE_W (SIZE_W),
        .LEN_W  (LEN_W),
        .BYTES  (BYTES)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .desc_valid (desc_valid),
        .desc_ready (desc_ready),
        .desc_addr  (desc_addr),
        .desc_size  (desc_size),
        .in_valid   (in_valid),
        .in_last    (in_last),
        .in_ready   (in_ready),
        .wr_valid   (wr_valid),
        .wr_ready   (wr_ready),
        .wr_addr    (wr_addr),
        .word_clear (word_clear),
        .byte_put   (byte_put),
        .lane       (lane),
        .st_valid   (st_valid),
        .st_first   (st_first),
        .st_last    (st_last),
        .st_len     (st_len)
    );

    rxw_lane_packer #(
        .BYTES (BYTES)
    ) u_pack (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (word_clear),
        .put   (byte_put),
        .lane  (lane),
        .din   (in_data),
        .data  (wr_data),
        .be    (wr_be)
    );

    // Status word assembly: flags in the low bits, length in the upper field.
    always_comb begin
        st_word                       = '0;
        st_word[BIT_LAST]             = st_last;
        st_word[BIT_FIRST]            = st_first;
        st_word[LEN_LSB +: LEN_W]     = st_len;
    end

    // R3: every write enables at least one lane
    a_r3_be_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_be != '0));
    // R9: data and enables stay stable while the write is stalled
    a_r9_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> ($stable(wr_data) && $stable(wr_be)));
    // R9: no byte intake while a write is pending
    a_r9_no_intake: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !in_ready);
endmodule

// File: tb/rxbuf_word_writer_tb.sv
module rxbuf_word_writer_tb;
    localparam int NV  = 6;
    localparam int MEM = 1024;
    localparam int V_ADDR [NV] = '{'h12, 'h20, 'h35, 'h07, 'h40, 'h01};
    localparam int V_SIZE [NV] = '{64,   16,   21,   30,   100,  25};
    localparam int V_LEN  [NV] = '{16,   40,   16,   60,   1,    50};
    localparam int V_STAL [NV] = '{0,    0,    0,    1,    0,    1};
    localparam int V_FBE  [NV] = '{'hFC, 'hFF, 'hE0, 'h80, 'h01, 'hFE};
    localparam int V_LBE  [NV] = '{'h03, 'hFF, 'h1F, 'h1F, 'h01, 'h06};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        desc_valid = 1'b0;
    logic        desc_ready;
    logic [31:0] desc_addr = '0;
    logic [13:0] desc_size = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        wr_valid;
    logic        wr_ready = 1'b1;
    logic [31:0] wr_addr;
    logic [63:0] wr_data;
    logic [7:0]  wr_be;
    logic        st_valid;
    logic [31:0] st_word;

    rxbuf_word_writer u_dut (
        .clk(clk), .rst_n(rst_n),
        .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_addr(desc_addr), .desc_size(desc_size),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be(wr_be),
        .st_valid(st_valid), .st_word(st_word)
    );

    always #10 clk = ~clk;

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [7:0] mem [MEM];
    logic [7:0] exp_mem [MEM];
    int dq [8];
    int dcnt = 0, dptr = 0, flen = 0, bptr = 0, vsel = 0, stall = 0;
    int words = 0, misalign = 0, hold_err = 0, scnt = 0;
    int first_be = -1, last_be = 0;
    int st_q [8];
    bit got_last = 0, done = 0;
    bit prev_stall = 0;
    logic [31:0] p_addr; logic [63:0] p_data; logic [7:0] p_be;

    task automatic check(string req, int act, int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    function automatic logic [7:0] pat(int v, int k);
        return 8'(v * 37 + k * 5 + 1);
    endfunction

    // Input driver: updates stimulus on the falling edge.
    initial forever begin
        @(negedge clk);
        cyc++;
        desc_valid = rst_n && (dptr < dcnt);
        desc_addr  = (dptr < dcnt) ? 32'(dq[dptr]) : 32'h0;
        desc_size  = 14'(V_SIZE[vsel]);
        in_valid   = rst_n && (bptr < flen);
        in_data    = pat(vsel, bptr);
        in_last    = (bptr == flen - 1);
        wr_ready   = !(stall != 0 && (cyc % 3) != 0);
    end

    // Monitor: records handshakes, memory writes and status words.
    initial forever begin
        @(posedge clk);
        if (rst_n) begin
            if (prev_stall && (!wr_valid || wr_addr != p_addr || wr_data != p_data || wr_be != p_be))
                hold_err++;
            if (prev_stall && in_valid && in_ready) hold_err++;
            prev_stall = wr_valid && !wr_ready;
            p_addr = wr_addr; p_data = wr_data; p_be = wr_be;
            if (desc_valid && desc_ready) dptr++;
            if (in_valid && in_ready) bptr++;
            if (wr_valid && wr_ready) begin
                words++;
                if (wr_addr[2:0] != 3'd0) misalign++;
                if (first_be < 0) first_be = int'(wr_be);
                last_be = int'(wr_be);
                for (int k = 0; k < 8; k++)
                    if (wr_be[k] && int'(wr_addr) + k < MEM) mem[int'(wr_addr) + k] = wr_data[k*8 +: 8];
            end
            if (st_valid) begin
                if (scnt < 8) st_q[scnt] = int'(st_word);
                scnt++;
                if (st_word[0]) got_last = 1;
            end
        end else prev_stall = 0;
    end

    initial begin
        #(20 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 desc_ready", int'(desc_ready), 1);
        check("R1 in_ready", int'(in_ready), 0);
        check("R1 wr_valid", int'(wr_valid), 0);
        check("R1 st_valid", int'(st_valid), 0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            int rem, pos, nb, ew;
            int est [8];
            @(negedge clk);
            for (int i = 0; i < MEM; i++) begin mem[i] = 8'hEE; exp_mem[i] = 8'hEE; end
            rem = V_LEN[v]; pos = 0; nb = 0; ew = 0;
            while (rem > 0) begin
                int a, off, n;
                a = V_ADDR[v] + 128 * nb; off = a % 8;
                n = (V_SIZE[v] - off < rem) ? V_SIZE[v] - off : rem;
                dq[nb] = a;
                for (int k = 0; k < n; k++) exp_mem[a + k] = pat(v, pos + k);
                ew += (off + n + 7) / 8;
                pos += n; rem -= n;
                est[nb] = ((nb == 0) ? 2 : 0) | ((rem == 0) ? (1 | (V_LEN[v] << 16)) : 0);
                nb++;
            end
            vsel = v; stall = V_STAL[v];
            words = 0; misalign = 0; hold_err = 0; scnt = 0; got_last = 0;
            first_be = -1; last_be = 0;
            bptr = 0; dptr = 0; dcnt = nb; flen = V_LEN[v];
            for (int t = 0; t < 3000 && !got_last; t++) @(negedge clk);
            repeat (2) @(negedge clk);
            check("R10 memory image", int'(mem == exp_mem), 1);
            check("R3 dummy lanes untouched / R10", int'(mem == exp_mem), 1);
            check("R2 word count", words, ew);
            check("R2 alignment", misalign, 0);
            check("R3 first byte enables", first_be, V_FBE[v]);
            check("R3 last byte enables", last_be, V_LBE[v]);
            check("R5 descriptors used", dptr, nb);
            check("R7 status count", scnt, nb);
            for (int j = 0; j < nb && j < 8; j++)
                check("R7 R8 status word", st_q[j], est[j]);
            check("R9 stall hold", hold_err, 0);
            check("R6 waits for new descriptor", int'(desc_ready && !in_ready), 1);
            if (v == 0) check("R4 three words", words, 3);
        end

        // R6: a second frame begins in the next descriptor despite space left
        @(negedge clk);
        check("R6 frame boundary consumed all bytes", bptr, V_LEN[NV-1]);

        // R1: reset in the middle of a frame returns to the idle state
        @(negedge clk);
        for (int i = 0; i < MEM; i++) mem[i] = 8'hEE;
        vsel = 0; stall = 1; bptr = 0; dptr = 0; dq[0] = 'h100; dcnt = 1; flen = 30;
        repeat (6) @(negedge clk);
        rst_n = 1'b0; flen = 0; dcnt = 0;
        @(negedge clk);
        @(negedge clk);
        check("R1 mid-frame reset desc_ready", int'(desc_ready), 1);
        check("R1 mid-frame reset in_ready", int'(in_ready), 0);
        check("R1 mid-frame reset wr_valid", int'(wr_valid), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule